// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the device side of a receive path built on a ring of descriptors in memory. Software programs the ring size in bytes, a base address and two ring indices, a head and a tail. Every descriptor from head up to, but not including, tail belongs to the hardware. Software hands descriptors back by moving tail forward. The engine moves head forward as it fills descriptors.

Incoming frames arrive as a stream of byte beats, and the final beat of each frame is flagged. For each frame the engine writes back a byte count and a status byte into the descriptor store. A frame longer than the configured buffer size is spread over consecutive descriptors. Three one-cycle events report what happens: a frame was completed, the pool of hardware-owned descriptors fell to a selectable fraction of the ring, or a frame found no descriptor to use. Payload movement and address filtering live elsewhere. The descriptor store is an internal RAM, and software can read it back through a lookup port.

Top module: `rxr_ring_engine`

## Requirements
- R1: After a synchronous reset, all host registers read as zero and no event output is high.
- R2: The host registers sit at these byte offsets: control 0x0100, base low 0x2800, base high 0x2804, ring length in bytes 0x2808, head 0x2810, tail 0x2818. Each register reads back the value last written to it. The head and tail keep only the index width. The ring holds (ring length / 16) descriptors.
- R3: A frame of at most one buffer size takes one descriptor, the one at head. That descriptor's length field is set to the frame's byte count and its status to 0x03 (bit 0 done, bit 1 end of packet). Head then advances by one, and it wraps from the last descriptor back to 0.
- R4: A frame longer than the buffer size fills consecutive descriptors. Every descriptor except the final one gets length equal to the buffer size and status 0x01. The final descriptor gets the remaining byte count and status 0x03.
- R5: The buffer size comes from control bits 17:16 (codes 0..3) together with bit 25. With bit 25 clear the sizes are 2048, 1024, 512 and 256. With bit 25 set the sizes are 16x those values, except code 0, which is reserved and behaves as 2048.
- R6: When a new descriptor is needed and head equals tail, nothing is written and head does not move. The rest of the frame is discarded, and the overrun event pulses for one cycle. If this happens in the middle of a frame, the descriptors already written keep status 0x01.
- R7: Control bit 1 enables reception. It is sampled only when a frame starts. A frame that starts while the bit is clear is ignored with no write-back and no event. Clearing the bit during a frame does not cut that frame short.
- R8: The completion event pulses once, in the cycle after each end-of-packet write-back.
- R9: The owned count is (tail - head) modulo the ring size. Control bits 9:8 select the threshold: code 0 gives ring/2, code 1 gives ring/4, code 2 gives ring/8, and code 3 disables the event. The threshold event pulses once when a head advance takes the owned count from above the threshold to at or below it.
- R10: A host tail write in the same cycle as a head advance takes effect together with the advance, and the threshold is judged on the new head and the new tail. A host head write in the same cycle as an advance overrides the advance.
- R11: The lookup port returns, without delay, the length and status last written to the selected descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_waddr | input | 16 | Host write byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_raddr | input | 16 | Host read byte offset |
| reg_rdata | output | 32 | Host read data (combinational) |
| rx_beat | input | 1 | One frame byte present this cycle |
| rx_last | input | 1 | The beat is the final byte of its frame |
| desc_idx | input | IDX_W | Descriptor lookup index |
| desc_len | output | 16 | Length field of the looked-up descriptor |
| desc_sts | output | 8 | Status byte of the looked-up descriptor |
| evt_rxt | output | 1 | Frame completed pulse |
| evt_min | output | 1 | Owned descriptors reached threshold pulse |
| evt_ovr | output | 1 | No descriptor available, frame data dropped |

## Verification
A host write to tail or head can land on the same clock edge as a head advance caused by a descriptor write-back. The bench provokes this by issuing the register write on the final beat of a frame. For the tail case, the ring is first set so that the advance alone would cross the threshold, and the concurrent tail write lifts the new owned count back above it. The bench then judges three things: no threshold pulse occurs, both the new tail and the advanced head read back, and, for a head write, the written value wins while the descriptor at the old head still receives its write-back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int LEN_W = 16;

    localparam logic [15:0] OFS_CTRL    = 16'h0100;
    localparam logic [15:0] OFS_BASE_LO = 16'h2800;
    localparam logic [15:0] OFS_BASE_HI = 16'h2804;
    localparam logic [15:0] OFS_RLEN    = 16'h2808;
    localparam logic [15:0] OFS_HEAD    = 16'h2810;
    localparam logic [15:0] OFS_TAIL    = 16'h2818;

    localparam int CTL_EN      = 1;
    localparam int CTL_THR_LO  = 8;
    localparam int CTL_BSZ_LO  = 16;
    localparam int CTL_BSZ_EXT = 25;

    localparam int STS_DONE = 0;
    localparam int STS_LAST = 1;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [7:0]       sts;
    } desc_wb_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_FILL = 2'd1,
        FS_DROP = 2'd2
    } fill_st_t;

    function automatic logic [LEN_W-1:0] bufsize_decode(input logic [1:0] code, input logic ext);
        logic [LEN_W-1:0] base;
        case (code)
            2'd0:    base = 16'd2048;
            2'd1:    base = 16'd1024;
            2'd2:    base = 16'd512;
            default: base = 16'd256;
        endcase
        if (ext && code != 2'd0) begin
            return base << 4;
        end
        return base;
    endfunction
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram
    import rxr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_wb_t         wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_wb_t         rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    desc_wb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [15:0]      reg_waddr,
    input  logic [31:0]      reg_wdata,
    input  logic [15:0]      reg_raddr,
    output logic [31:0]      reg_rdata,
    input  logic             adv,
    output logic             ctrl_en,
    output logic [1:0]       bsz_code,
    output logic             bsz_ext,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             evt_min
);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic [31:0]      ctrl_q, base_lo_q, base_hi_q, rlen_q;
    logic [IDX_W-1:0] head_q, tail_q, head_d, tail_d;
    logic [IDX_W-1:0] ring_n, head_inc, head_wrap, thr;
    logic [1:0]       thr_sel;
    logic             wr_head, wr_tail, thr_on, min_hit;

    function automatic logic [IDX_W-1:0] owned(input logic [IDX_W-1:0] h,
                                               input logic [IDX_W-1:0] t,
                                               input logic [IDX_W-1:0] n);
        return (t >= h) ? (t - h) : (t + n - h);
    endfunction

    assign ring_n    = rlen_q[4 +: IDX_W];
    assign head_inc  = head_q + IDX_ONE;
    assign head_wrap = (head_inc == ring_n) ? '0 : head_inc;
    assign wr_head   = reg_we && (reg_waddr == OFS_HEAD);
    assign wr_tail   = reg_we && (reg_waddr == OFS_TAIL);

    always_comb begin
        head_d = head_q;
        if (wr_head) begin
            head_d = reg_wdata[IDX_W-1:0];
        end else if (adv) begin
            head_d = head_wrap;
        end
        tail_d = wr_tail ? reg_wdata[IDX_W-1:0] : tail_q;
    end

    assign thr_sel = ctrl_q[CTL_THR_LO +: 2];
    assign thr_on  = (thr_sel != 2'd3);
    assign thr     = ring_n >> ({1'b0, thr_sel} + 3'd1);
    assign min_hit = adv && thr_on
                     && (owned(head_q, tail_q, ring_n) > thr)
                     && (owned(head_d, tail_d, ring_n) <= thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            base_lo_q <= '0;
            base_hi_q <= '0;
            rlen_q    <= '0;
            head_q    <= '0;
            tail_q    <= '0;
            evt_min   <= 1'b0;
        end else begin
            if (reg_we && reg_waddr == OFS_CTRL)    ctrl_q    <= reg_wdata;
            if (reg_we && reg_waddr == OFS_BASE_LO) base_lo_q <= reg_wdata;
            if (reg_we && reg_waddr == OFS_BASE_HI) base_hi_q <= reg_wdata;
            if (reg_we && reg_waddr == OFS_RLEN)    rlen_q    <= reg_wdata;
            head_q  <= head_d;
            tail_q  <= tail_d;
            evt_min <= min_hit;
        end
    end

    always_comb begin
        case (reg_raddr)
            OFS_CTRL:    reg_rdata = ctrl_q;
            OFS_BASE_LO: reg_rdata = base_lo_q;
            OFS_BASE_HI: reg_rdata = base_hi_q;
            OFS_RLEN:    reg_rdata = rlen_q;
            OFS_HEAD:    reg_rdata = {{(32-IDX_W){1'b0}}, head_q};
            OFS_TAIL:    reg_rdata = {{(32-IDX_W){1'b0}}, tail_q};
            default:     reg_rdata = '0;
        endcase
    end

    assign ctrl_en  = ctrl_q[CTL_EN];
    assign bsz_code = ctrl_q[CTL_BSZ_LO +: 2];
    assign bsz_ext  = ctrl_q[CTL_BSZ_EXT];
    assign head     = head_q;
    assign tail     = tail_q;

    p_adv_room_r6: assert property (@(posedge clk) disable iff (rst)
        adv |-> (head_q != tail_q));

    p_min_single_r9: assert property (@(posedge clk) disable iff (rst)
        evt_min |=> !evt_min);

    p_tail_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_tail |=> $stable(tail_q));
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
    import rxr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_beat,
    input  logic             rx_last,
    input  logic             enable,
    input  logic [LEN_W-1:0] bufsize,
    input  logic             ring_empty,
    input  logic [IDX_W-1:0] head,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output desc_wb_t         wb_data,
    output logic             evt_rxt,
    output logic             evt_ovr
);
    fill_st_t         state_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d, next_cnt;
    logic             take, rxt_d, ovr_d;

    assign next_cnt = cnt_q + LEN_W'(1);
    assign wb_idx   = head;

    always_comb begin
        st_d        = state_q;
        cnt_d       = cnt_q;
        wb_en       = 1'b0;
        rxt_d       = 1'b0;
        ovr_d       = 1'b0;
        take        = 1'b0;
        wb_data.len = next_cnt;
        wb_data.sts = '0;
        if (rx_beat) begin
            unique case (state_q)
                FS_IDLE: begin
                    if (enable) take = 1'b1;
                    else if (!rx_last) st_d = FS_DROP;
                end
                FS_FILL: take = 1'b1;
                default: if (rx_last) st_d = FS_IDLE;
            endcase
            if (take) begin
                if (cnt_q == '0 && ring_empty) begin
                    ovr_d = 1'b1;
                    cnt_d = '0;
                    st_d  = rx_last ? FS_IDLE : FS_DROP;
                end else if (rx_last) begin
                    wb_en                 = 1'b1;
                    wb_data.sts[STS_DONE] = 1'b1;
                    wb_data.sts[STS_LAST] = 1'b1;
                    rxt_d                 = 1'b1;
                    cnt_d                 = '0;
                    st_d                  = FS_IDLE;
                end else if (next_cnt >= bufsize) begin
                    wb_en                 = 1'b1;
                    wb_data.sts[STS_DONE] = 1'b1;
                    cnt_d                 = '0;
                    st_d                  = FS_FILL;
                end else begin
                    cnt_d = next_cnt;
                    st_d  = FS_FILL;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
            evt_rxt <= 1'b0;
            evt_ovr <= 1'b0;
        end else begin
            state_q <= st_d;
            cnt_q   <= cnt_d;
            evt_rxt <= rxt_d;
            evt_ovr <= ovr_d;
        end
    end

    p_wb_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_data.len != '0));

    p_drop_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_DROP) |-> !wb_en);

    p_eop_event_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_data.sts[STS_LAST]) |=> evt_rxt);

    p_ovr_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(evt_ovr && evt_rxt));
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
    import rxr_pkg::*;
#(
    parameter int MAX_DESC = 16,
    localparam int IDX_W   = $clog2(MAX_DESC) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [15:0]      reg_waddr,
    input  logic [31:0]      reg_wdata,
    input  logic [15:0]      reg_raddr,
    output logic [31:0]      reg_rdata,
    input  logic             rx_beat,
    input  logic             rx_last,
    input  logic [IDX_W-1:0] desc_idx,
    output logic [15:0]      desc_len,
    output logic [7:0]       desc_sts,
    output logic             evt_rxt,
    output logic             evt_min,
    output logic             evt_ovr
);
    logic             ctrl_en, bsz_ext, wb_en;
    logic [1:0]       bsz_code;
    logic [IDX_W-1:0] head, tail, wb_idx;
    logic [LEN_W-1:0] bufsize;
    desc_wb_t         wb_data, rd_data;

    assign bufsize = bufsize_decode(bsz_code, bsz_ext);

    rxr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .adv       (wb_en),
        .ctrl_en   (ctrl_en),
        .bsz_code  (bsz_code),
        .bsz_ext   (bsz_ext),
        .head      (head),
        .tail      (tail),
        .evt_min   (evt_min)
    );

    rxr_fill #(.IDX_W(IDX_W)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .rx_beat    (rx_beat),
        .rx_last    (rx_last),
        .enable     (ctrl_en),
        .bufsize    (bufsize),
        .ring_empty (head == tail),
        .head       (head),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .evt_rxt    (evt_rxt),
        .evt_ovr    (evt_ovr)
    );

    rxr_desc_ram #(.IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .wr_en   (wb_en),
        .wr_idx  (wb_idx),
        .wr_data (wb_data),
        .rd_idx  (desc_idx),
        .rd_data (rd_data)
    );

    assign desc_len = rd_data.len;
    assign desc_sts = rd_data.sts;
endmodule

// File: tb/tb_rxr_ring_engine.sv
module tb_rxr_ring_engine;
    import rxr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_DESC   = 16;
    localparam int IDX_W      = $clog2(MAX_DESC) + 1;
    localparam int RING       = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_we = 1'b0;
    logic [15:0]      reg_waddr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [15:0]      reg_raddr = '0;
    logic [31:0]      reg_rdata;
    logic             rx_beat = 1'b0;
    logic             rx_last = 1'b0;
    logic [IDX_W-1:0] desc_idx = '0;
    logic [15:0]      desc_len;
    logic [7:0]       desc_sts;
    logic             evt_rxt, evt_min, evt_ovr;

    rxr_ring_engine #(.MAX_DESC(MAX_DESC)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .rx_beat(rx_beat), .rx_last(rx_last), .desc_idx(desc_idx),
        .desc_len(desc_len), .desc_sts(desc_sts), .evt_rxt(evt_rxt),
        .evt_min(evt_min), .evt_ovr(evt_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int got_rxt = 0, got_min = 0, got_ovr = 0;
    int exp_rxt = 0, exp_min = 0, exp_ovr = 0;
    int m_head = 0, m_tail = 0, m_n = 0, m_en = 0, m_sel = 0, m_bs = 2048;
    int exp_len [64];
    int exp_sts [64];
    int wl [64];
    int wl_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (evt_rxt) got_rxt++;
            if (evt_min) got_min++;
            if (evt_ovr) got_ovr++;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bs_of(input int code, input int ext);
        int b = 2048 >> code;
        if (ext != 0 && code != 0) b = b * 16;
        return b;
    endfunction

    function automatic int wrapi(input int h);
        return (h + 1 == m_n) ? 0 : h + 1;
    endfunction

    function automatic int own(input int h, input int t);
        return (t >= h) ? t - h : t + m_n - h;
    endfunction

    task automatic apply_write(input logic [15:0] a, input logic [31:0] d);
        if (a == OFS_CTRL) begin
            m_en  = int'(d[1]);
            m_sel = int'(d[9:8]);
            m_bs  = bs_of(int'(d[17:16]), int'(d[25]));
        end
        if (a == OFS_RLEN) m_n = int'(d) / 16;
        if (a == OFS_HEAD) m_head = int'(d[IDX_W-1:0]);
        if (a == OFS_TAIL) m_tail = int'(d[IDX_W-1:0]);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        apply_write(a, d);
    endtask

    task automatic rd(input logic [15:0] a, output int d);
        reg_raddr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic cfg(input int en, input int sel, input int code, input int ext);
        wr(OFS_CTRL, 32'((en << 1) | (sel << 8) | (code << 16) | (ext << 25)));
    endtask

    task automatic model_frame(input int n, input bit sw, input logic [15:0] sa, input logic [31:0] sd);
        int rem = n;
        wl_n = 0;
        if (m_en != 0) begin
            while (rem > 0) begin
                int take, nh, nt, thr;
                bit fin;
                if (m_head == m_tail) begin
                    exp_ovr++;
                    break;
                end
                fin  = (rem <= m_bs);
                take = fin ? rem : m_bs;
                exp_len[m_head] = take;
                exp_sts[m_head] = fin ? 3 : 1;
                wl[wl_n] = m_head; wl_n++;
                nh = wrapi(m_head);
                nt = m_tail;
                if (fin && sw && sa == OFS_HEAD) nh = int'(sd[IDX_W-1:0]);
                if (fin && sw && sa == OFS_TAIL) nt = int'(sd[IDX_W-1:0]);
                thr = m_n >> (m_sel + 1);
                if (m_sel != 3 && own(m_head, m_tail) > thr && own(nh, nt) <= thr) exp_min++;
                if (fin) exp_rxt++;
                m_head = nh; m_tail = nt;
                rem -= take;
            end
        end
        if (sw) apply_write(sa, sd);
    endtask

    task automatic post_check(input string dtag);
        int v;
        rd(OFS_HEAD, v);
        check_eq("R3", "head", v, m_head);
        check_eq("R8", "completion events", got_rxt, exp_rxt);
        check_eq("R9", "threshold events", got_min, exp_min);
        check_eq("R6", "overrun events", got_ovr, exp_ovr);
        for (int i = 0; i < wl_n; i++) begin
            desc_idx = IDX_W'(wl[i]);
            #1;
            check_eq(dtag, "desc len", int'(desc_len), exp_len[wl[i]]);
            check_eq(dtag, "desc status", int'(desc_sts), exp_sts[wl[i]]);
        end
    endtask

    task automatic send(input int n, input bit sw, input logic [15:0] sa, input logic [31:0] sd, input string dtag);
        model_frame(n, sw, sa, sd);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_beat = 1'b1;
            rx_last = (i == n - 1);
            if (i == n - 1 && sw) begin
                reg_we = 1'b1; reg_waddr = sa; reg_wdata = sd;
            end
        end
        @(negedge clk);
        rx_beat = 1'b0; rx_last = 1'b0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        post_check(dtag);
    endtask

    task automatic refill();
        wr(OFS_TAIL, 32'((m_head + RING - 1) % RING));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, h0, min0, ovr0, rxt0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(OFS_HEAD, v); check_eq("R1", "head", v, 0);
        rd(OFS_TAIL, v); check_eq("R1", "tail", v, 0);
        rd(OFS_CTRL, v); check_eq("R1", "ctrl", v, 0);
        rd(OFS_RLEN, v); check_eq("R1", "ring length", v, 0);
        check_eq("R1", "events", int'({evt_rxt, evt_min, evt_ovr}), 0);

        // R2 register readback
        wr(OFS_BASE_LO, 32'h1234_5670); rd(OFS_BASE_LO, v); check_eq("R2", "base lo", v, 32'h1234_5670);
        wr(OFS_BASE_HI, 32'h0000_00AB); rd(OFS_BASE_HI, v); check_eq("R2", "base hi", v, 32'h0000_00AB);
        wr(OFS_RLEN, 32'(RING * 16));   rd(OFS_RLEN, v);    check_eq("R2", "ring length", v, RING * 16);
        wr(OFS_HEAD, 32'd3);            rd(OFS_HEAD, v);    check_eq("R2", "head", v, 3);
        wr(OFS_TAIL, 32'd5);            rd(OFS_TAIL, v);    check_eq("R2", "tail", v, 5);
        cfg(1, 0, 3, 0);                rd(OFS_CTRL, v);    check_eq("R2", "ctrl", v, 32'h0003_0002);

        // R3 R4 R11 basic frames, 256-byte buffers
        wr(OFS_HEAD, 32'd0);
        wr(OFS_TAIL, 32'd7);
        send(10, 1'b0, 16'h0, 32'h0, "R3");
        send(256, 1'b0, 16'h0, 32'h0, "R3");
        send(257, 1'b0, 16'h0, 32'h0, "R4");
        desc_idx = IDX_W'(2); #1;
        check_eq("R11", "lookup len idx2", int'(desc_len), 256);
        check_eq("R11", "lookup sts idx2", int'(desc_sts), 1);

        // R5 buffer size sweep over all codes
        for (int c = 0; c < 8; c++) begin
            int bs;
            cfg(1, 0, c % 4, c / 4);
            refill();
            bs = bs_of(c % 4, c / 4);
            send(1, 1'b0, 16'h0, 32'h0, "R3");
            send(bs, 1'b0, 16'h0, 32'h0, "R5");
            h0 = m_head;
            send(bs + 1, 1'b0, 16'h0, 32'h0, "R5");
            desc_idx = IDX_W'(h0); #1;
            check_eq("R5", "first desc len", int'(desc_len), (c == 4) ? 2048 : bs);
        end

        // R9 threshold per select code, ring drained by single-byte frames
        for (int s = 0; s < 4; s++) begin
            cfg(1, s, 3, 0);
            refill();
            min0 = got_min; ovr0 = got_ovr;
            for (int k = 0; k < RING; k++) send(1, 1'b0, 16'h0, 32'h0, "R3");
            check_eq("R9", "threshold pulses in drain", got_min - min0, (s < 3) ? 1 : 0);
            check_eq("R6", "overrun when empty", got_ovr - ovr0, 1);
        end

        // R6 overrun in the middle of a frame
        cfg(1, 3, 3, 0);
        h0 = m_head;
        wr(OFS_TAIL, 32'((m_head + 1) % RING));
        ovr0 = got_ovr;
        send(300, 1'b0, 16'h0, 32'h0, "R6");
        check_eq("R6", "mid-frame overrun", got_ovr - ovr0, 1);
        desc_idx = IDX_W'(h0); #1;
        check_eq("R6", "partial desc status", int'(desc_sts), 1);

        // R7 disabled at frame start, then disabled mid-frame
        cfg(0, 3, 3, 0);
        refill();
        h0 = m_head; rxt0 = got_rxt;
        send(20, 1'b0, 16'h0, 32'h0, "R7");
        rd(OFS_HEAD, v);
        check_eq("R7", "head unchanged while disabled", v, h0);
        check_eq("R7", "no completion while disabled", got_rxt - rxt0, 0);
        cfg(1, 3, 3, 0);
        rxt0 = got_rxt;
        send(300, 1'b1, OFS_CTRL, 32'h0003_0300, "R7");
        check_eq("R7", "frame finishes after mid-frame disable", got_rxt - rxt0, 1);

        // R10 tail write together with an advance
        cfg(1, 0, 3, 0);
        wr(OFS_TAIL, 32'((m_head + 5) % RING));
        min0 = got_min;
        h0 = m_head;
        send(1, 1'b1, OFS_TAIL, 32'((m_head + 7) % RING), "R10");
        check_eq("R10", "no threshold pulse after lifted tail", got_min - min0, 0);
        rd(OFS_TAIL, v);
        check_eq("R10", "tail written", v, (h0 + 7) % RING);
        rd(OFS_HEAD, v);
        check_eq("R10", "head advanced", v, (h0 + 1) % RING);

        // R10 head write together with an advance
        cfg(1, 3, 3, 0);
        h0 = m_head;
        send(1, 1'b1, OFS_HEAD, 32'((m_head + 3) % RING), "R10");
        rd(OFS_HEAD, v);
        check_eq("R10", "host head wins", v, (h0 + 3) % RING);
        desc_idx = IDX_W'(h0); #1;
        check_eq("R10", "old head written", int'(desc_sts), 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule